// File: doc/BRIEF.md
# Crypto Engine Control Registers

This block is the register file that software uses to control and observe a command-driven crypto engine. It decodes 32-bit register reads and writes at fixed byte offsets. It returns a fixed engine status word and a fixed queue status word. It keeps an interrupt status register and an interrupt enable register, and it drives one level-sensitive interrupt line.

The command sequencer that sits beside this block reports two kinds of event. The first is an invalid-command pulse. The second is a flag command, which carries a raise bit and an 8-bit info code. Each flag command stores its info code in a readable register. If its raise bit is set, it also raises an interrupt status bit. Software clears interrupt status bits by writing ones to them. A write at the FIFO offset is not stored here: it is passed to the sequencer as a single-cycle word pulse.

Reads are combinational: `rdata_o` shows the selected register in the cycle `rd_en_i` is high. Writes take effect at the clock edge at which `wr_en_i` is high.

Top module: `crypto_ctrl_regs`

## Requirements
- R1: After reset the status offset 0x0C reads 0x00003F80 and the queue status offset 0x24 reads 0x00000002. Interrupt status (0x18), interrupt enable (0x1C), watermark (0x20) and flag info (0x30) read 0. `irq_o` is low and `fifo_valid_o` is low.
- R2: A read returns 0 at any offset other than 0x0C, 0x18, 0x1C, 0x20, 0x24 and 0x30. This includes the FIFO offset 0x200 and unaligned byte addresses. `rdata_o` is also 0 while `rd_en_i` is low.
- R3: A write to interrupt status (0x18) clears every implemented bit that is 1 in the written value and leaves the other bits unchanged.
- R4: `irq_o` is high exactly when the bitwise AND of interrupt status and interrupt enable is nonzero. It reflects the registers as they stand after each clock edge.
- R5: A flag event with the raise bit high sets interrupt status bit 5. A flag event with the raise bit low leaves bit 5 unchanged.
- R6: Every flag event stores `flag_info_i` in the flag info register. The register reads back zero-extended in bits 7:0.
- R7: An invalid-command pulse sets interrupt status bit 2. Only bits 2 and 5 of interrupt status are implemented; all other bits read 0.
- R8: If a hardware set and a software clear hit the same interrupt status bit in one cycle, the bit ends up set.
- R9: A write at offset 0x200 drives `fifo_valid_o` high for exactly one cycle after the write edge, with `fifo_data_o` equal to the written word.
- R10: Writes to read-only offsets (0x0C, 0x20, 0x24, 0x30) and to unmapped offsets change no register and produce no FIFO pulse.
- R11: Interrupt enable (0x1C) is a full 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| evt_invalid_i | input | 1 | Invalid-command pulse from the sequencer |
| evt_flag_i | input | 1 | Flag-command pulse from the sequencer |
| flag_raise_i | input | 1 | Raise bit of the flag command, qualified by evt_flag_i |
| flag_info_i | input | 8 | Info code of the flag command, qualified by evt_flag_i |
| fifo_valid_o | output | 1 | One-cycle pulse carrying a FIFO word |
| fifo_data_o | output | 32 | FIFO word to the sequencer |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a collision: a sequencer event and a software clear of the same interrupt status bit at the same clock edge. The bench creates it by driving the event pulse and the clear write in the same low phase of the clock. It also mixes in a collision where one bit is cleared while the other is set. The interrupt line is checked against every combination of the two status bits with a range of enable masks. The address space is swept word by word and at unaligned addresses. All 256 info codes are fed through flag events with the raise bit low, and the status register is checked to confirm that bit 5 stays clear.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned INFO_W      = 8;
  localparam int unsigned OFS_STATUS  = 32'h00C;
  localparam int unsigned OFS_ISTS    = 32'h018;
  localparam int unsigned OFS_IEN     = 32'h01C;
  localparam int unsigned OFS_WMARK   = 32'h020;
  localparam int unsigned OFS_QSTS    = 32'h024;
  localparam int unsigned OFS_FINFO   = 32'h030;
  localparam int unsigned OFS_FIFO    = 32'h200;
  localparam int unsigned BIT_INVALID = 2;
  localparam int unsigned BIT_FLAG    = 5;
  localparam logic [DATA_W-1:0] STATUS_RST = 32'h0000_3F80;
  localparam logic [DATA_W-1:0] QSTS_RST   = 32'h0000_0002;
  localparam logic [DATA_W-1:0] WMARK_RST  = 32'h0000_0000;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_ISTS, SEL_IEN, SEL_WMARK, SEL_QSTS, SEL_FINFO, SEL_FIFO
  } reg_sel_e;
endpackage

// File: rtl/ccr_decode.sv
`timescale 1ns/1ps
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ISTS   = ADDR_W'(OFS_ISTS);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_WMARK  = ADDR_W'(OFS_WMARK);
  localparam logic [ADDR_W-1:0] A_QSTS   = ADDR_W'(OFS_QSTS);
  localparam logic [ADDR_W-1:0] A_FINFO  = ADDR_W'(OFS_FINFO);
  localparam logic [ADDR_W-1:0] A_FIFO   = ADDR_W'(OFS_FIFO);

  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == A_STATUS) sel_o = SEL_STATUS;
    else if (addr_i == A_ISTS)   sel_o = SEL_ISTS;
    else if (addr_i == A_IEN)    sel_o = SEL_IEN;
    else if (addr_i == A_WMARK)  sel_o = SEL_WMARK;
    else if (addr_i == A_QSTS)   sel_o = SEL_QSTS;
    else if (addr_i == A_FINFO)  sel_o = SEL_FINFO;
    else if (addr_i == A_FIFO)   sel_o = SEL_FIFO;
  end
endmodule

// File: rtl/ccr_irq.sv
`timescale 1ns/1ps
module ccr_irq
  import ccr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sts_wr_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         evt_invalid_i,
  input  logic         evt_flag_raise_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] set_v, clr_v, sts_d, sts_q, en_q, impl_mask;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == BIT_INVALID) begin : g_inv
      assign set_v[i]     = evt_invalid_i;
      assign impl_mask[i] = 1'b1;
    end else if (i == BIT_FLAG) begin : g_flag
      assign set_v[i]     = evt_flag_raise_i;
      assign impl_mask[i] = 1'b1;
    end else begin : g_none
      assign set_v[i]     = 1'b0;
      assign impl_mask[i] = 1'b0;
    end
  end

  assign clr_v = {W{sts_wr_i}} & wdata_i;
  // set has priority over clear
  assign sts_d = (set_v | (sts_q & ~clr_v)) & impl_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(evt_invalid_i) |-> sts_q[BIT_INVALID]);
  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(sts_wr_i) && $past(wdata_i[BIT_FLAG]) && !$past(evt_flag_raise_i)
    |-> !sts_q[BIT_FLAG]);
  a_r5_flag_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(evt_flag_raise_i) |-> sts_q[BIT_FLAG]);
  a_r7_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sts_q) <= 2);
  a_r4_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0) && (sts_q != '0));
  a_r11_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(en_wr_i) |-> $stable(en_q));
endmodule

// File: rtl/ccr_fwd.sv
`timescale 1ns/1ps
module ccr_fwd
  import ccr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= push_i;
      if (push_i) data_o <= wdata_i;
    end
  end

  a_r9_fifo_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(push_i) |-> valid_o && (data_o == $past(wdata_i)));
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(push_i) |-> !valid_o);
endmodule

// File: rtl/crypto_ctrl_regs.sv
`timescale 1ns/1ps
module crypto_ctrl_regs
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              evt_invalid_i,
  input  logic              evt_flag_i,
  input  logic              flag_raise_i,
  input  logic [7:0]        flag_info_i,
  output logic              fifo_valid_o,
  output logic [31:0]       fifo_data_o,
  output logic              irq_o
);
  reg_sel_e            sel;
  logic [DATA_W-1:0]   ists, ien;
  logic [INFO_W-1:0]   finfo_q;

  ccr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .sel_o(sel));

  ccr_irq #(.W(DATA_W)) u_irq (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .sts_wr_i         (wr_en_i && (sel == SEL_ISTS)),
    .en_wr_i          (wr_en_i && (sel == SEL_IEN)),
    .wdata_i          (wdata_i),
    .evt_invalid_i    (evt_invalid_i),
    .evt_flag_raise_i (evt_flag_i && flag_raise_i),
    .sts_o            (ists),
    .en_o             (ien),
    .irq_o            (irq_o)
  );

  ccr_fwd #(.W(DATA_W)) u_fwd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i && (sel == SEL_FIFO)),
    .wdata_i (wdata_i),
    .valid_o (fifo_valid_o),
    .data_o  (fifo_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         finfo_q <= '0;
    else if (evt_flag_i) finfo_q <= flag_info_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (sel)
        SEL_STATUS: rdata_o = STATUS_RST;
        SEL_ISTS:   rdata_o = ists;
        SEL_IEN:    rdata_o = ien;
        SEL_WMARK:  rdata_o = WMARK_RST;
        SEL_QSTS:   rdata_o = QSTS_RST;
        SEL_FINFO:  rdata_o = {{(DATA_W-INFO_W){1'b0}}, finfo_q};
        default:    rdata_o = '0;
      endcase
    end
  end

  a_r10_finfo_sw_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(evt_flag_i) |-> $stable(finfo_q));
  a_r6_finfo_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(evt_flag_i) |-> finfo_q == $past(flag_info_i));
endmodule

// File: tb/crypto_ctrl_regs_tb.sv
`timescale 1ns/1ps
module crypto_ctrl_regs_tb_top;
  localparam int unsigned AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ev_inv = 0, ev_flag = 0, fl_raise = 0;
  logic [7:0] fl_info = '0;
  logic fvalid, irq;
  logic [31:0] fdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_ists = 0, m_ien = 0, m_finfo = 0;

  always #10 clk = ~clk; // 50 MHz

  crypto_ctrl_regs #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_invalid_i(ev_inv), .evt_flag_i(ev_flag),
    .flag_raise_i(fl_raise), .flag_info_i(fl_info), .fifo_valid_o(fvalid),
    .fifo_data_o(fdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      12'h00C: return 32'h3F80;
      12'h018: return m_ists;
      12'h01C: return m_ien;
      12'h020: return 32'h0;
      12'h024: return 32'h2;
      12'h030: return m_finfo;
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; #2; d = rdata; rd_en = 0; addr = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp_rd(a), req, d, exp_rd(a));
  endtask

  // one cycle of stimulus; returns at the following negedge
  task automatic cyc(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                     input bit inv, input bit fl, input bit rs, input logic [7:0] inf);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ev_inv = inv; ev_flag = fl; fl_raise = rs; fl_info = inf;
    @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0; ev_inv = 0; ev_flag = 0; fl_raise = 0; fl_info = '0;
    // model update
    if (w && a == 12'h018) m_ists = m_ists & ~d;
    if (w && a == 12'h01C) m_ien = d;
    if (inv) m_ists[2] = 1'b1;
    if (fl && rs) m_ists[5] = 1'b1;
    if (fl) m_finfo = {24'h0, inf};
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 8'h0);
  endtask

  task automatic irq_chk(input string req);
    bit e;
    e = |(m_ists & m_ien);
    chk(irq == e, req, {31'h0, irq}, {31'h0, e});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] en_pat [6];
    en_pat[0] = 32'h0; en_pat[1] = 32'h4; en_pat[2] = 32'h20;
    en_pat[3] = 32'h24; en_pat[4] = 32'hFFFF_FFFF; en_pat[5] = 32'hFFFF_FFDB;

    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(12'h00C, "R1 status"); rd_chk(12'h024, "R1 qstatus");
    rd_chk(12'h018, "R1 ists");   rd_chk(12'h01C, "R1 ien");
    rd_chk(12'h020, "R1 wmark");  rd_chk(12'h030, "R1 finfo");
    chk(irq == 0, "R1 irq", {31'h0, irq}, 0);
    chk(fvalid == 0, "R1 fifo_valid", {31'h0, fvalid}, 0);

    // populate state, then sweep address space (R2)
    wr(12'h01C, 32'hA5A5_5A5A);                 // R11 full-width enable
    rd_chk(12'h01C, "R11 ien readback");
    cyc(0, 0, 0, 1, 1, 0, 8'h3C);               // R7 invalid + R6 info
    rd_chk(12'h018, "R7 invalid sets bit2");
    rd_chk(12'h030, "R6 finfo");
    irq_chk("R4 masked");
    for (int a = 0; a < (1 << AW); a += 4) rd_chk(AW'(a), "R2 sweep");
    for (int a = 1; a < 64; a++) if (a % 4 != 0) rd_chk(AW'(a), "R2 unaligned");
    rd_chk(12'h200, "R2 fifo reads zero");
    rd_en = 0; addr = 12'h00C; #2;
    chk(rdata == 0, "R2 rd_en low", rdata, 0);
    addr = '0;

    // R10 writes to read-only and unmapped offsets
    foreach (en_pat[k]) begin end
    wr(12'h00C, 32'hFFFF_FFFF); chk(fvalid == 0, "R10 no pulse", {31'h0, fvalid}, 0);
    wr(12'h020, 32'hFFFF_FFFF); wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF); wr(12'h100, 32'hFFFF_FFFF); wr(12'h019, 32'hFFFF_FFFF);
    chk(fvalid == 0, "R10 no pulse", {31'h0, fvalid}, 0);
    rd_chk(12'h00C, "R10 status"); rd_chk(12'h020, "R10 wmark");
    rd_chk(12'h024, "R10 qstatus"); rd_chk(12'h030, "R10 finfo");
    rd_chk(12'h018, "R10 ists"); rd_chk(12'h01C, "R10 ien");

    // R9 FIFO forward
    wr(12'h200, 32'hDEAD_BEEF);
    chk(fvalid == 1, "R9 valid", {31'h0, fvalid}, 1);
    chk(fdata == 32'hDEAD_BEEF, "R9 data", fdata, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(fvalid == 0, "R9 one cycle", {31'h0, fvalid}, 0);
    @(negedge clk);
    wr_en = 1; addr = 12'h200; wdata = 32'h1111_0001;
    @(negedge clk); wdata = 32'h2222_0002;
    chk(fvalid && fdata == 32'h1111_0001, "R9 burst 1", fdata, 32'h1111_0001);
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
    chk(fvalid && fdata == 32'h2222_0002, "R9 burst 2", fdata, 32'h2222_0002);
    @(negedge clk);
    chk(fvalid == 0, "R9 burst end", {31'h0, fvalid}, 0);

    // R3/R4/R5/R7 sweep of status combos x enable patterns
    for (int s = 0; s < 4; s++) begin
      foreach (en_pat[k]) begin
        wr(12'h018, 32'hFFFF_FFFF);
        rd_chk(12'h018, "R3 clear all");
        wr(12'h01C, en_pat[k]);
        cyc(0, 0, 0, s[0], s[1], s[1], 8'(s));
        rd_chk(12'h018, "R5 R7 status combo");
        irq_chk("R4 irq combo");
      end
    end
    // R3 selective clear: both set, clear bit5 only
    wr(12'h01C, 32'h20);
    cyc(0, 0, 0, 1, 1, 1, 8'h77);
    wr(12'h018, 32'h20);
    rd_chk(12'h018, "R3 selective clear");
    irq_chk("R4 after clear");
    wr(12'h018, 32'h0);
    rd_chk(12'h018, "R3 zero write no effect");

    // R8 collisions
    cyc(1, 12'h018, 32'h4, 1, 0, 0, 8'h0);
    rd_chk(12'h018, "R8 set wins bit2");
    cyc(1, 12'h018, 32'h24, 0, 1, 1, 8'h55);
    rd_chk(12'h018, "R8 set wins bit5 clear bit2");
    irq_chk("R8 irq");

    // R5/R6 exhaustive info sweep with raise low
    wr(12'h018, 32'hFFFF_FFFF);
    for (int v = 0; v < 256; v++) begin
      cyc(0, 0, 0, 0, 1, 0, 8'(v));
      rd_chk(12'h030, "R6 info sweep");
      rd_chk(12'h018, "R5 no raise");
    end
    irq_chk("R5 irq quiet");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule